// File: doc/BRIEF.md
# General-Purpose I/O Bank with Masked Pin Updates

This block is one 32-pin general-purpose I/O bank sitting behind a plain single-cycle register port. Software programs a direction word to choose which pads are driven and an output word to set their levels. The pad side has three separate vectors: one for incoming levels, one for outgoing levels and one for output enables.

The main feature is a pair of half-word update registers. Each covers sixteen pins. The upper sixteen bits of the written word are an inverted mask and the lower sixteen bits are the new levels. A single write can therefore change chosen pins in one half of the bank without first reading the output word back. Incoming pad levels are resynchronised through two flops and then exposed in a read-only input word.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset the direction word and the output word are all zero, so pad_oe and pad_out are zero and both words read back as zero.
- R2: Register index 0 is the direction word. It is readable and writable. pad_oe[i] equals direction bit i, where 1 means driven output and 0 means input. A write shows on pad_oe at the next clock edge.
- R3: Register index 1 is the output word. It is readable and writable, and pad_out follows it one clock edge after a write. With no write, pad_out and pad_oe hold their values.
- R4: Register index 2 is the low-half update register. For each i in 0..15, wdata bit 16+i set to 0 loads pin i from wdata bit i, and set to 1 keeps pin i. Pins 16..31 are unchanged.
- R5: Register index 3 is the high-half update register. For each i in 0..15, wdata bit 16+i set to 0 loads pin 16+i from wdata bit i, and set to 1 keeps it. Pins 0..15 are unchanged. Writing 0xBDEF_4210 sets pins 20, 25 and 30 and leaves every other pin as it was.
- R6: A masked update takes effect at the clock edge of the write. Updates on consecutive cycles accumulate, and a later read of index 1 returns the merged word.
- R7: Reads of index 2 and index 3 return zero.
- R8: Register index 4 is the read-only input word. It returns pad_in delayed by two clock edges. A new pad level is not visible after one edge. Writes to index 4 change nothing.
- R9: Indexes 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid in the same cycle |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when bus_rd is low |
| pad_in | input | 32 | Levels sampled from the pads |
| pad_out | output | 32 | Levels driven to the pads |
| pad_oe | output | 32 | Per-pad output enable |

## Verification
The assertions check on every cycle that each write to the direction word, the output word or either half-update register lands on the pads one edge later with the correct per-bit merge. They also check that pads never move without a write to a live index, that the update registers read as zero, and that the input word equals pad_in from two edges earlier. The bench scenarios are needed for the rest. Reset values are read back through the port. The pin 20/25/30 example is checked as a literal value. Mask patterns of all-ones and mixed bits are exercised, as are updates on consecutive cycles read back through index 1. The bench also shows that a fresh pad level is still hidden after one edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DIR = 3'd0,
    REG_OUT = 3'd1,
    REG_MLO = 3'd2,
    REG_MHI = 3'd3,
    REG_IN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  out_q
);
  localparam int unsigned HALF = PIN_W / 2;

  logic [PIN_W-1:0] dir_d;
  logic [PIN_W-1:0] out_d;
  logic             dir_en;
  logic             out_en;
  logic [HALF-1:0]  keep;
  logic [HALF-1:0]  lvl;
  logic [HALF-1:0]  lo_merged;
  logic [HALF-1:0]  hi_merged;

  assign keep = wdata[PIN_W-1:HALF];
  assign lvl  = wdata[HALF-1:0];

  // Per-pin merge for each half: a set mask bit keeps the current level.
  generate
    for (genvar i = 0; i < HALF; i++) begin : g_merge
      assign lo_merged[i] = keep[i] ? out_q[i]      : lvl[i];
      assign hi_merged[i] = keep[i] ? out_q[HALF+i] : lvl[i];
    end
  endgenerate

  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    dir_en = 1'b0;
    out_en = 1'b0;
    if (wr_en) begin
      case (addr)
        REG_DIR: begin
          dir_d  = wdata;
          dir_en = 1'b1;
        end
        REG_OUT: begin
          out_d  = wdata;
          out_en = 1'b1;
        end
        REG_MLO: begin
          out_d  = {out_q[PIN_W-1:HALF], lo_merged};
          out_en = 1'b1;
        end
        REG_MHI: begin
          out_d  = {hi_merged, out_q[HALF-1:0]};
          out_en = 1'b1;
        end
        default: begin
          dir_en = 1'b0;
          out_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_W = 32
) (
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [PIN_W-1:0]  dir_q,
  input  logic [PIN_W-1:0]  out_q,
  input  logic [PIN_W-1:0]  in_q,
  output logic [PIN_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        REG_DIR: rdata = dir_q;
        REG_OUT: rdata = out_q;
        REG_IN:  rdata = in_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_W     = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe
);
  logic             rst_int_n;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] out_q;
  logic [PIN_W-1:0] in_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  gpio_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pad_in),
    .dout  (in_q)
  );

  gpio_out_regs #(.PIN_W(PIN_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  gpio_read_mux #(.PIN_W(PIN_W)) u_rd (
    .rd_en (bus_rd),
    .addr  (bus_addr),
    .dir_q (dir_q),
    .out_q (out_q),
    .in_q  (in_q),
    .rdata (bus_rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_W = 32
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [REG_AW-1:0] bus_addr,
  input logic [PIN_W-1:0]  bus_wdata,
  input logic [PIN_W-1:0]  bus_rdata,
  input logic [PIN_W-1:0]  pad_in,
  input logic [PIN_W-1:0]  pad_out,
  input logic [PIN_W-1:0]  pad_oe
);
  localparam int unsigned HALF = PIN_W / 2;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)          age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (pad_out == '0 && pad_oe == '0));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == REG_DIR) |=> pad_oe == $past(bus_wdata));

  p_out_write_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == REG_OUT) |=> pad_out == $past(bus_wdata));

  // R3, R8, R9: pads move only on a write to a live index
  p_pads_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_wr || bus_addr >= REG_IN) |=> ($stable(pad_out) && $stable(pad_oe)));

  p_mask_lo_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == REG_MLO) |=>
      (pad_out[PIN_W-1:HALF] == $past(pad_out[PIN_W-1:HALF]) &&
       pad_out[HALF-1:0] == ((~$past(bus_wdata[PIN_W-1:HALF]) & $past(bus_wdata[HALF-1:0])) |
                             ($past(bus_wdata[PIN_W-1:HALF]) & $past(pad_out[HALF-1:0])))));

  p_mask_hi_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == REG_MHI) |=>
      (pad_out[HALF-1:0] == $past(pad_out[HALF-1:0]) &&
       pad_out[PIN_W-1:HALF] == ((~$past(bus_wdata[PIN_W-1:HALF]) & $past(bus_wdata[HALF-1:0])) |
                                 ($past(bus_wdata[PIN_W-1:HALF]) & $past(pad_out[PIN_W-1:HALF])))));

  p_mask_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && (bus_addr == REG_MLO || bus_addr == REG_MHI)) |-> bus_rdata == '0);

  p_input_delay_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && bus_addr == REG_IN && age_q >= 2'd2) |-> bus_rdata == $past(pad_in, 2));

  p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_rd || bus_addr > REG_IN) |-> bus_rdata == '0);
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(.PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_bank_test.sv
module gpio_mask_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] m_dir, m_out;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_mask_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  function automatic logic [15:0] merge16(input logic [15:0] cur, input logic [31:0] w);
    return (w[31:16] & cur) | (~w[31:16] & w[15:0]);
  endfunction

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    case (a)
      3'd0: m_dir = d;
      3'd1: m_out = d;
      3'd2: m_out[15:0]  = merge16(m_out[15:0], d);
      3'd3: m_out[31:16] = merge16(m_out[31:16], d);
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: compares read data against the scoreboard queue.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_rd) begin
        if (exp_q.size() == 0) begin
          check("read without expectation", bus_rdata, 32'hx);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_in = '0; m_dir = '0; m_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    do_read(3'd0, 32'h0, "R1 dir read");
    do_read(3'd1, 32'h0, "R1 out read");

    // R2 direction
    do_write(3'd0, 32'hF0F0_00FF);
    check("R2 pad_oe", pad_oe, 32'hF0F0_00FF);
    do_read(3'd0, 32'hF0F0_00FF, "R2 dir read");

    // R3 output word
    do_write(3'd1, 32'h1234_5678);
    check("R3 pad_out", pad_out, 32'h1234_5678);
    do_read(3'd1, 32'h1234_5678, "R3 out read");
    repeat (3) @(negedge clk);
    check("R3 hold", pad_out, 32'h1234_5678);

    // R5 literal example from a cleared word
    do_write(3'd1, 32'h0);
    do_write(3'd3, 32'hBDEF_4210);
    check("R5 pins 20/25/30", pad_out, 32'h4210_0000);
    do_write(3'd1, 32'h0000_A5A5);
    do_write(3'd3, 32'hBDEF_4210);
    check("R5 low half kept", pad_out, 32'h4210_A5A5);
    do_write(3'd3, 32'hFFFF_0000);
    check("R5 full mask no change", pad_out, m_out);

    // R4 low half
    do_write(3'd1, 32'hFFFF_FFFF);
    do_write(3'd2, 32'h00FF_0000);
    check("R4 mixed mask", pad_out, 32'hFFFF_00FF);
    do_write(3'd2, 32'h0000_1234);
    check("R4 zero mask", pad_out, 32'hFFFF_1234);

    // R6 back-to-back updates accumulate
    do_write(3'd1, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'hFF00_00AA;
    m_out[15:0] = merge16(m_out[15:0], 32'hFF00_00AA);
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 32'h00FF_5500;
    m_out[31:16] = merge16(m_out[31:16], 32'h00FF_5500);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 merged pads", pad_out, 32'h5500_00AA);
    do_read(3'd1, m_out, "R6 merged read");

    // R7 update registers read zero
    do_read(3'd2, 32'h0, "R7 low half read");
    do_read(3'd3, 32'h0, "R7 high half read");

    // R8 input word delay and write ignore
    do_write(3'd4, 32'hFFFF_FFFF);
    check("R8 write ignored out", pad_out, m_out);
    check("R8 write ignored dir", pad_oe, m_dir);
    do_read(3'd4, 32'h0, "R8 input before change");
    @(negedge clk);
    pad_in = 32'hC3C3_5A5A;
    do_read(3'd4, 32'h0, "R8 one edge not visible");
    do_read(3'd4, 32'hC3C3_5A5A, "R8 two edges visible");

    // R9 unused indexes
    for (int a = 5; a < 8; a++) begin
      do_write(3'(a), 32'hFFFF_FFFF);
      do_read(3'(a), 32'h0, "R9 unused read");
    end
    check("R9 out unchanged", pad_out, m_out);
    check("R9 dir unchanged", pad_oe, m_dir);
    do_read(3'd0, m_dir, "R9 dir read");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule